// File: doc/BRIEF.md
# Dual-Space Page Translation Unit

This block maps a 17-bit word address into a backplane slot number and a 22-bit physical word address. The mapping comes from a 256-entry on-chip table. That table holds two separate 128-entry address spaces. A mode input picks one space: user or privileged. Every entry names a target slot, a 12-bit physical page and four control bits. The lower 10 address bits are the offset within the page and pass straight through.

A lookup takes one cycle. Each lookup is checked against the entry's control bits. A successful lookup sets the accessed flag, and a successful write also sets the modified flag. These flag changes are written back to the table one cycle after the lookup. Lookups that fail report a cause code and leave the entry untouched. The operating system fills the table through a separate write port, and that port wins any clash with a lookup or with a flag write-back.

A three-state machine drives the response. From any state it moves as follows:
- to IDLE when no request is present;
- to XLATE when the request translates cleanly;
- to FAULT when the request is refused.

Top module: `ptu_top`

## Requirements
- R1: After reset the response outputs are all zero, and every table entry reads as zero, so it is not resident.
- R2: A request sampled at a clock edge produces a response with `rsp_valid` high during the following cycle. A cycle with no request gives `rsp_valid` low.
- R3: The table index is `{req_priv, req_vaddr[16:10]}`. User and privileged lookups with the same page bits therefore reach different entries.
- R4: Entry layout is as follows. Bits [19:16] hold the slot and bits [15:4] hold the physical page. The control bits are bit0 resident, bit1 write-protect, bit2 accessed and bit3 modified. A clean lookup returns that slot and `rsp_paddr = {page, req_vaddr[9:0]}`.
- R5: A lookup to an entry whose resident bit is clear faults with cause 2'b01. Slot and address read zero, and the entry is left unchanged.
- R6: A write to a resident entry with write-protect set faults with cause 2'b10 and changes nothing. A read of such an entry succeeds.
- R7: A clean lookup sets the accessed bit, and a clean write also sets the modified bit. `rsp_flags` shows the updated control bits, and they persist for later lookups, including one in the very next cycle. On a fault `rsp_flags` shows the stored bits.
- R8: A table write and a lookup to the same entry in the same cycle make the lookup see the newly written entry. A table write landing in the same cycle as a pending flag write-back to that entry wins.
- R9: A write to an entry that is both non-resident and write-protected reports cause 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_write | input | 1 | Request is a write |
| req_priv | input | 1 | 1 selects the privileged space |
| req_vaddr | input | 17 | Virtual word address |
| tbl_we | input | 1 | Table load strobe |
| tbl_idx | input | 8 | Table entry to load |
| tbl_data | input | 20 | Entry contents to load |
| rsp_valid | output | 1 | Response present |
| rsp_slot | output | 4 | Target backplane slot |
| rsp_paddr | output | 22 | Physical word address |
| rsp_fault | output | 1 | Lookup refused |
| rsp_cause | output | 2 | 01 not resident, 10 write protected, 00 none |
| rsp_flags | output | 4 | Entry control bits after this lookup |

## Verification
The assertions assume four things:
- requests and table loads are driven away from the clock edge;
- `req_write` is meaningful only while `req_valid` is high;
- the previous cycle's request inputs are what the response refers to;
- reset is held for several cycles before any traffic.

The stimulus changes inputs only on falling edges and keeps them at known levels throughout reset. It issues lookups back to back, so that flag write-back and forwarding are exercised without idle gaps. The collision cases are placed on exact cycles so that table loads meet lookups and pending write-backs.

// File: rtl/ptu_pkg.sv
package ptu_pkg;

    localparam int CTL_RES  = 0;
    localparam int CTL_WP   = 1;
    localparam int CTL_ACC  = 2;
    localparam int CTL_MOD  = 3;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ABSENT = 2'b01,
        CAUSE_WPROT  = 2'b10
    } cause_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_XLATE = 2'b01,
        S_FAULT = 2'b10
    } rsp_state_t;

endpackage

// File: rtl/ptu_table.sv
module ptu_table #(
    parameter int TIDX_W = 8,
    parameter int ENT_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [TIDX_W-1:0] tbl_idx,
    input  logic [ENT_W-1:0]  tbl_data,
    input  logic              wb_en,
    input  logic [TIDX_W-1:0] wb_idx,
    input  logic [ENT_W-1:0]  wb_data,
    input  logic [TIDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << TIDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    // Later assignment wins: the table load overrides a write-back to the same entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (wb_en) begin
                mem[wb_idx] <= wb_data;
            end
            if (tbl_we) begin
                mem[tbl_idx] <= tbl_data;
            end
        end
    end

    always_comb begin
        if (tbl_we && (tbl_idx == rd_idx)) begin
            rd_data = tbl_data;
        end else if (wb_en && (wb_idx == rd_idx)) begin
            rd_data = wb_data;
        end else begin
            rd_data = mem[rd_idx];
        end
    end

    // R8: a table load always lands, even against a write-back
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tbl_we) |-> (mem[$past(tbl_idx)] == $past(tbl_data)));

endmodule

// File: rtl/ptu_check.sv
module ptu_check
    import ptu_pkg::*;
#(
    parameter int CTRL_W = 4
) (
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              is_write,
    output logic              fault,
    output cause_t            cause,
    output logic [CTRL_W-1:0] ctrl_out
);
    always_comb begin
        ctrl_out = ctrl_in;
        fault    = 1'b0;
        cause    = CAUSE_NONE;
        if (!ctrl_in[CTL_RES]) begin
            fault = 1'b1;
            cause = CAUSE_ABSENT;
        end else if (is_write && ctrl_in[CTL_WP]) begin
            fault = 1'b1;
            cause = CAUSE_WPROT;
        end else begin
            ctrl_out[CTL_ACC] = 1'b1;
            if (is_write) begin
                ctrl_out[CTL_MOD] = 1'b1;
            end
        end
    end

    // R9: absence outranks write protection
    always_comb begin
        if (!ctrl_in[CTL_RES]) begin
            p_absent_first_r9: assert (cause == CAUSE_ABSENT);
        end
    end

endmodule

// File: rtl/ptu_top.sv
module ptu_top
    import ptu_pkg::*;
#(
    parameter int VA_W   = 17,
    parameter int OFF_W  = 10,
    parameter int SLOT_W = 4,
    parameter int PPN_W  = 12,
    parameter int CTRL_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_priv,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic                     tbl_we,
    input  logic [VA_W-OFF_W:0]      tbl_idx,
    input  logic [SLOT_W+PPN_W+CTRL_W-1:0] tbl_data,
    output logic                     rsp_valid,
    output logic [SLOT_W-1:0]        rsp_slot,
    output logic [PPN_W+OFF_W-1:0]   rsp_paddr,
    output logic                     rsp_fault,
    output logic [1:0]               rsp_cause,
    output logic [CTRL_W-1:0]        rsp_flags
);
    localparam int IDX_W  = VA_W - OFF_W;
    localparam int TIDX_W = IDX_W + 1;
    localparam int ENT_W  = SLOT_W + PPN_W + CTRL_W;
    localparam int PA_W   = PPN_W + OFF_W;

    rsp_state_t state, state_nx;

    logic [TIDX_W-1:0] lk_idx;
    logic [ENT_W-1:0]  lk_entry;
    logic [CTRL_W-1:0] lk_ctrl, lk_ctrl_new;
    logic [PPN_W-1:0]  lk_ppn;
    logic [SLOT_W-1:0] lk_slot;
    logic              lk_fault;
    cause_t            lk_cause;

    logic              wb_en;
    logic [TIDX_W-1:0] wb_idx;
    logic [ENT_W-1:0]  wb_data;

    logic [SLOT_W-1:0] pl_slot;
    logic [PPN_W-1:0]  pl_ppn;
    logic [OFF_W-1:0]  pl_off;
    cause_t            pl_cause;
    logic [CTRL_W-1:0] pl_flags;

    assign lk_idx  = {req_priv, req_vaddr[VA_W-1:OFF_W]};
    assign lk_ctrl = lk_entry[CTRL_W-1:0];
    assign lk_ppn  = lk_entry[CTRL_W +: PPN_W];
    assign lk_slot = lk_entry[ENT_W-1 -: SLOT_W];

    ptu_table #(.TIDX_W(TIDX_W), .ENT_W(ENT_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .tbl_we  (tbl_we),
        .tbl_idx (tbl_idx),
        .tbl_data(tbl_data),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_data (wb_data),
        .rd_idx  (lk_idx),
        .rd_data (lk_entry)
    );

    ptu_check #(.CTRL_W(CTRL_W)) u_check (
        .ctrl_in (lk_ctrl),
        .is_write(req_write),
        .fault   (lk_fault),
        .cause   (lk_cause),
        .ctrl_out(lk_ctrl_new)
    );

    always_comb begin
        if (!req_valid) begin
            state_nx = S_IDLE;
        end else if (lk_fault) begin
            state_nx = S_FAULT;
        end else begin
            state_nx = S_XLATE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_slot  <= '0;
            pl_ppn   <= '0;
            pl_off   <= '0;
            pl_cause <= CAUSE_NONE;
            pl_flags <= '0;
            wb_en    <= 1'b0;
            wb_idx   <= '0;
            wb_data  <= '0;
        end else begin
            wb_en <= req_valid && !lk_fault;
            if (req_valid) begin
                pl_slot  <= lk_slot;
                pl_ppn   <= lk_ppn;
                pl_off   <= req_vaddr[OFF_W-1:0];
                pl_cause <= lk_cause;
                pl_flags <= lk_fault ? lk_ctrl : lk_ctrl_new;
                wb_idx   <= lk_idx;
                wb_data  <= {lk_slot, lk_ppn, lk_ctrl_new};
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_slot  = '0;
        rsp_paddr = '0;
        rsp_fault = 1'b0;
        rsp_cause = CAUSE_NONE;
        rsp_flags = '0;
        unique case (state)
            S_IDLE: begin
            end
            S_XLATE: begin
                rsp_valid = 1'b1;
                rsp_slot  = pl_slot;
                rsp_paddr = {pl_ppn, pl_off};
                rsp_flags = pl_flags;
            end
            S_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_cause = pl_cause;
                rsp_flags = pl_flags;
            end
            default: begin
            end
        endcase
    end

    // R2: one-cycle response
    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_req_no_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4: offset passes through unchanged
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));
    // R5: faults carry no translation
    p_fault_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_slot == '0 && rsp_paddr == '0 && rsp_cause != 2'b00));
    // R6: protected resident page refuses writes
    p_wp_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_write) && rsp_flags[CTL_WP] && rsp_flags[CTL_RES]) |-> rsp_fault);
    // R7: clean lookups mark accessed, clean writes mark modified
    p_accessed_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_flags[CTL_ACC]);
    p_modified_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && $past(req_write)) |-> rsp_flags[CTL_MOD]);
    // R7: write-back is issued exactly for clean lookups
    p_wb_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (rsp_valid && !rsp_fault));

endmodule

// File: tb/tb_ptu_top.sv
module tb_ptu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic [16:0] req_vaddr = '0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_idx = '0;
    logic [19:0] tbl_data = '0;
    logic        rsp_valid, rsp_fault;
    logic [3:0]  rsp_slot, rsp_flags;
    logic [21:0] rsp_paddr;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptu_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_vaddr(req_vaddr), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_data(tbl_data), .rsp_valid(rsp_valid),
        .rsp_slot(rsp_slot), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_flags(rsp_flags)
    );

    typedef struct packed {
        logic        priv;
        logic        wr;
        logic [16:0] va;
        logic        fault;
        logic [1:0]  cause;
        logic [3:0]  slot;
        logic [21:0] pa;
        logic [3:0]  flags;
    } vec_t;

    localparam int NV = 11;
    // Requirement per row: R4/R7, R7, R7, R3, R4, R6, R5, R9, R3, R1, R3/R7
    localparam vec_t VECS [NV] = '{
        {1'b0, 1'b0, {7'd5,   10'h3FF}, 1'b0, 2'b00, 4'h3, 22'h048FFF, 4'h5},
        {1'b0, 1'b1, {7'd5,   10'h001}, 1'b0, 2'b00, 4'h3, 22'h048C01, 4'hD},
        {1'b0, 1'b0, {7'd5,   10'h002}, 1'b0, 2'b00, 4'h3, 22'h048C02, 4'hD},
        {1'b1, 1'b0, {7'd5,   10'h010}, 1'b0, 2'b00, 4'h9, 22'h2AF010, 4'h5},
        {1'b0, 1'b0, {7'd127, 10'h000}, 1'b0, 2'b00, 4'hF, 22'h3FFC00, 4'h7},
        {1'b0, 1'b1, {7'd127, 10'h005}, 1'b1, 2'b10, 4'h0, 22'h000000, 4'h7},
        {1'b0, 1'b0, {7'd0,   10'h000}, 1'b1, 2'b01, 4'h0, 22'h000000, 4'h2},
        {1'b0, 1'b1, {7'd0,   10'h000}, 1'b1, 2'b01, 4'h0, 22'h000000, 4'h2},
        {1'b1, 1'b0, {7'd0,   10'h3FF}, 1'b0, 2'b00, 4'h1, 22'h0007FF, 4'h5},
        {1'b0, 1'b0, {7'd1,   10'h000}, 1'b1, 2'b01, 4'h0, 22'h000000, 4'h0},
        {1'b1, 1'b1, {7'd5,   10'h020}, 1'b0, 2'b00, 4'h9, 22'h2AF020, 4'hD}
    };

    task automatic check_rsp(input string req, input logic v, input logic f,
                             input logic [1:0] c, input logic [3:0] s,
                             input logic [21:0] p, input logic [3:0] fl);
        checks++;
        if ({rsp_valid, rsp_fault, rsp_cause, rsp_slot, rsp_paddr, rsp_flags} !==
            {v, f, c, s, p, fl}) begin
            fails++;
            $display("FAIL %s: actual v=%b f=%b c=%b s=%h pa=%h fl=%h expected v=%b f=%b c=%b s=%h pa=%h fl=%h",
                     req, rsp_valid, rsp_fault, rsp_cause, rsp_slot, rsp_paddr, rsp_flags,
                     v, f, c, s, p, fl);
        end
    endtask

    task automatic load(input logic [7:0] idx, input logic [19:0] data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_data = data;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check_rsp("R1", 1'b0, 1'b0, 2'b00, 4'h0, 22'h0, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: no request, no response
        check_rsp("R2", 1'b0, 1'b0, 2'b00, 4'h0, 22'h0, 4'h0);

        load(8'd5,   {4'h3, 12'h123, 4'b0001});
        load(8'd133, {4'h9, 12'hABC, 4'b0001});
        load(8'd127, {4'hF, 12'hFFF, 4'b0011});
        load(8'd0,   {4'h2, 12'h010, 4'b0010});
        load(8'd128, {4'h1, 12'h001, 4'b0001});

        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check_rsp($sformatf("R3/R4/R5/R6/R7/R9 vector %0d", i-1), 1'b1,
                          VECS[i-1].fault, VECS[i-1].cause, VECS[i-1].slot,
                          VECS[i-1].pa, VECS[i-1].flags);
            end
            if (i < NV) begin
                req_valid = 1'b1; req_priv = VECS[i].priv;
                req_write = VECS[i].wr; req_vaddr = VECS[i].va;
            end else begin
                req_valid = 1'b0; req_write = 1'b0;
            end
        end
        @(negedge clk);
        check_rsp("R2 idle after burst", 1'b0, 1'b0, 2'b00, 4'h0, 22'h0, 4'h0);

        // R8: load and lookup of the same entry in one cycle
        tbl_we = 1'b1; tbl_idx = 8'd10; tbl_data = {4'h6, 12'h200, 4'b0001};
        req_valid = 1'b1; req_priv = 1'b0; req_write = 1'b1; req_vaddr = {7'd10, 10'h00A};
        @(negedge clk);
        check_rsp("R8 same-cycle load", 1'b1, 1'b0, 2'b00, 4'h6, 22'h08000A, 4'hD);
        // R8: load meets the pending write-back of that lookup
        tbl_we = 1'b1; tbl_idx = 8'd10; tbl_data = {4'h7, 12'h300, 4'b0001};
        req_valid = 1'b0; req_write = 1'b0;
        @(negedge clk);
        tbl_we = 1'b0;
        req_valid = 1'b1; req_vaddr = {7'd10, 10'h001};
        @(negedge clk);
        check_rsp("R8 load beats write-back", 1'b1, 1'b0, 2'b00, 4'h7, 22'h0C0001, 4'h5);
        req_valid = 1'b0;

        // R1: reset clears the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b1; req_priv = 1'b1; req_vaddr = {7'd5, 10'h0};
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R1 table cleared", 1'b1, 1'b1, 2'b01, 4'h0, 22'h0, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule